// File: doc/BRIEF.md
# Bus Bridge Master-Abort Handler

This block sits beside the initiator side of a bridge port that drives a target-side parallel bus with conventional PCI signalling. Every cycle it samples the bridge's own frame strobe and the device-select response from the bus. When the bridge starts a cycle and no device claims it within a fixed window, the block declares a master abort. It then decides what follows from the class of the transaction that failed.

The transaction classes are handled as follows:
- **Delayed reads and delayed writes.** The block remembers, per queue tag, that the transaction was aborted. When the initiator later repeats that request, the block asks the bridge not to claim it, which passes the abort back to the initiator. The following cycle it retires the tag from the delayed queue.
- **Posted writes.** The data is discarded, and a one-clock system-error pulse may be raised, subject to three register bits.
- **Special cycles converted from a configuration cycle.** These are expected to end unclaimed. They raise no status and only signal that the originating configuration cycle must be disconnected.

Status outputs are one-clock set pulses aimed at write-one-to-clear registers held elsewhere.

Top module: `abort_handler`

## Requirements
- R1: Take the first clock edge at which frameN is sampled low while idle as edge 1. If devselN is sampled low at any of edges 1 through 5, the cycle is claimed. Otherwise the abort outputs are high for exactly the one cycle that follows edge 6.
- R2: On an abort of any class other than special, exactly one status pulse fires. setPriMa fires when txnOnSec was 0 at edge 1, and setSecMa fires when it was 1.
- R3: On an abort of class 0 (delayed read) or class 1 (delayed write), the tag given with txnTag is marked. A later single-cycle repeatValid carrying that tag drives suppressDevsel high in the same cycle.
- R4: The cycle after a suppressed repeat, retireValid is high for one cycle and retireTag equals the repeated tag. The mark is then gone, so a further repeat of that tag is not suppressed.
- R5: On an abort of class 2 (posted write), discardPost pulses for one cycle and no tag is marked.
- R6: serrN is driven low for the single abort cycle only if all of these hold: the class is posted write, maMode is 1, serrEn is 1 and postedMaDis is 0. In every other case serrN stays high.
- R7: On an abort of class 3 (converted special cycle), neither status pulse fires, discardPost and serrN stay inactive, and cfgDisconnect pulses for one cycle.
- R8: A claimed cycle produces no status, discard, disconnect or system-error output.
- R9: While rstN is low at a clock edge, all marks and the timeout count are cleared. Afterwards a repeat of a previously marked tag is not suppressed.
- R10: A repeat whose tag is not marked is not suppressed and retires nothing. Marks held by other tags are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Synchronous active-low reset |
| frameN | input | 1 | Frame strobe the bridge drives on the target bus, active low |
| devselN | input | 1 | Device-select response from the target bus, active low |
| txnClass | input | 2 | Class of the cycle: 0 delayed read, 1 delayed write, 2 posted write, 3 converted special cycle |
| txnTag | input | TAG_W | Delayed-queue tag of the cycle |
| txnOnSec | input | 1 | 1 when the target bus is the secondary side |
| maMode | input | 1 | Master-abort mode control bit |
| serrEn | input | 1 | System-error enable control bit |
| postedMaDis | input | 1 | Disables system error for posted-write master aborts |
| repeatValid | input | 1 | Initiator repeat of a delayed request presented (one cycle) |
| repeatTag | input | TAG_W | Tag of the repeated request |
| setPriMa | output | 1 | Set pulse for the primary received-master-abort bit |
| setSecMa | output | 1 | Set pulse for the secondary received-master-abort bit |
| discardPost | output | 1 | Drop the aborted posted-write data |
| cfgDisconnect | output | 1 | Disconnect the originating configuration cycle after its first data phase |
| serrN | output | 1 | System error, active low, one clock per event |
| suppressDevsel | output | 1 | Do not claim the presented repeat |
| retireValid | output | 1 | Retire strobe to the delayed queue |
| retireTag | output | TAG_W | Tag being retired |

## Verification
Two functions can land in the same cycle: a new abort of a delayed transaction, and a repeat of a different tag that was marked earlier. The bench provokes this by presenting the repeat in exactly the cycle in which the abort pulse is visible. It then checks that the old tag is suppressed and retired on the next cycle, that the status pulse for the new abort still fires, and that the new tag is marked, which a later repeat exposes. The timeout window is checked at both edges: a claim on the fifth edge gives no abort, and a claim on the sixth edge gives one.

// File: rtl/abort_pkg.sv
package abort_pkg;

  typedef enum logic [1:0] {
    CLS_DLY_RD  = 2'd0,
    CLS_DLY_WR  = 2'd1,
    CLS_POSTED  = 2'd2,
    CLS_SPECIAL = 2'd3
  } txnClass_e;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_WATCH   = 2'd1,
    ST_CLAIMED = 2'd2,
    ST_DRAIN   = 2'd3
  } watchState_e;

  // Strobes from the watcher to the decision datapath.
  typedef struct packed {
    logic      abortHit;
    txnClass_e cls;
    logic      onSec;
  } abortEvt_t;

endpackage

// File: rtl/abort_ctrl.sv
module abort_ctrl
  import abort_pkg::*;
#(
  parameter int TAG_W = 2,
  parameter int LIMIT = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameN,
  input  logic             devselN,
  input  logic [1:0]       txnClass,
  input  logic [TAG_W-1:0] txnTag,
  input  logic             txnOnSec,
  output abortEvt_t        evt,
  output logic [TAG_W-1:0] evtTag
);

  localparam int CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LIMIT);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  watchState_e      state;
  logic [CNT_W-1:0] waitCnt;
  txnClass_e        clsQ;
  logic [TAG_W-1:0] tagQ;
  logic             secQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
      clsQ    <= CLS_DLY_RD;
      tagQ    <= '0;
      secQ    <= 1'b0;
      evt     <= '0;
      evtTag  <= '0;
    end else begin
      evt.abortHit <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (!frameN) begin
            clsQ    <= txnClass_e'(txnClass);
            tagQ    <= txnTag;
            secQ    <= txnOnSec;
            waitCnt <= CNT_ONE;
            state   <= devselN ? ST_WATCH : ST_CLAIMED;
          end
        end
        ST_WATCH: begin
          if (waitCnt == CNT_LAST) begin
            evt.abortHit <= 1'b1;
            evt.cls      <= clsQ;
            evt.onSec    <= secQ;
            evtTag       <= tagQ;
            waitCnt      <= '0;
            state        <= ST_DRAIN;
          end else if (!devselN) begin
            waitCnt <= '0;
            state   <= ST_CLAIMED;
          end else begin
            waitCnt <= waitCnt + CNT_ONE;
          end
        end
        ST_CLAIMED, ST_DRAIN: begin
          waitCnt <= '0;
          if (frameN) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1: an abort strobe lasts one clock only
  a_r1_single_abort: assert property (@(posedge clk) disable iff (!rstN)
    evt.abortHit |=> !evt.abortHit);

  // R1: the wait count never passes the window
  a_r1_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    waitCnt <= CNT_LAST);

  // R8: a claimed cycle never turns into an abort
  a_r8_claim_no_abort: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CLAIMED) |=> !evt.abortHit);

endmodule

// File: rtl/abort_dp.sv
module abort_dp
  import abort_pkg::*;
#(
  parameter int TAG_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  abortEvt_t        evt,
  input  logic [TAG_W-1:0] evtTag,
  input  logic             maMode,
  input  logic             serrEn,
  input  logic             postedMaDis,
  input  logic             repeatValid,
  input  logic [TAG_W-1:0] repeatTag,
  output logic             setPriMa,
  output logic             setSecMa,
  output logic             discardPost,
  output logic             cfgDisconnect,
  output logic             serrN,
  output logic             suppressDevsel,
  output logic             retireValid,
  output logic [TAG_W-1:0] retireTag
);

  localparam int ENTRIES = 1 << TAG_W;

  logic [ENTRIES-1:0] abortedQ;
  logic isDelayed, isPosted, isSpecial, countsAsError;

  always_comb begin
    isDelayed     = evt.abortHit && (evt.cls == CLS_DLY_RD || evt.cls == CLS_DLY_WR);
    isPosted      = evt.abortHit && (evt.cls == CLS_POSTED);
    isSpecial     = evt.abortHit && (evt.cls == CLS_SPECIAL);
    countsAsError = evt.abortHit && !isSpecial;
    setPriMa      = countsAsError && !evt.onSec;
    setSecMa      = countsAsError &&  evt.onSec;
    discardPost   = isPosted;
    cfgDisconnect = isSpecial;
    serrN         = !(isPosted && maMode && serrEn && !postedMaDis);
    suppressDevsel = repeatValid && abortedQ[repeatTag];
  end

  // One mark per delayed-queue entry; a new abort wins over a clear.
  for (genvar e = 0; e < ENTRIES; e++) begin : g_mark
    always_ff @(posedge clk) begin
      if (!rstN) begin
        abortedQ[e] <= 1'b0;
      end else if (isDelayed && evtTag == TAG_W'(e)) begin
        abortedQ[e] <= 1'b1;
      end else if (repeatValid && repeatTag == TAG_W'(e)) begin
        abortedQ[e] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      retireValid <= 1'b0;
      retireTag   <= '0;
    end else begin
      retireValid <= suppressDevsel;
      if (suppressDevsel) retireTag <= repeatTag;
    end
  end

  // R2: never both status sides at once
  a_r2_one_side: assert property (@(posedge clk) disable iff (!rstN)
    !(setPriMa && setSecMa));

  // R7: a special-cycle disconnect carries no status or error
  a_r7_special_quiet: assert property (@(posedge clk) disable iff (!rstN)
    cfgDisconnect |-> (!setPriMa && !setSecMa && serrN && !discardPost));

  // R6: system error is a single-clock event
  a_r6_serr_one_clock: assert property (@(posedge clk) disable iff (!rstN)
    !serrN |=> serrN);

  // R4: a retire always follows a suppressed repeat of the same tag
  a_r4_retire_follows: assert property (@(posedge clk) disable iff (!rstN)
    retireValid |-> ($past(suppressDevsel) && retireTag == $past(repeatTag)));

endmodule

// File: rtl/abort_handler.sv
module abort_handler
  import abort_pkg::*;
#(
  parameter int TAG_W = 2,
  parameter int LIMIT = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameN,
  input  logic             devselN,
  input  logic [1:0]       txnClass,
  input  logic [TAG_W-1:0] txnTag,
  input  logic             txnOnSec,
  input  logic             maMode,
  input  logic             serrEn,
  input  logic             postedMaDis,
  input  logic             repeatValid,
  input  logic [TAG_W-1:0] repeatTag,
  output logic             setPriMa,
  output logic             setSecMa,
  output logic             discardPost,
  output logic             cfgDisconnect,
  output logic             serrN,
  output logic             suppressDevsel,
  output logic             retireValid,
  output logic [TAG_W-1:0] retireTag
);

  abortEvt_t        evt;
  logic [TAG_W-1:0] evtTag;

  abort_ctrl #(.TAG_W(TAG_W), .LIMIT(LIMIT)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .frameN   (frameN),
    .devselN  (devselN),
    .txnClass (txnClass),
    .txnTag   (txnTag),
    .txnOnSec (txnOnSec),
    .evt      (evt),
    .evtTag   (evtTag)
  );

  abort_dp #(.TAG_W(TAG_W)) dp_i (
    .clk            (clk),
    .rstN           (rstN),
    .evt            (evt),
    .evtTag         (evtTag),
    .maMode         (maMode),
    .serrEn         (serrEn),
    .postedMaDis    (postedMaDis),
    .repeatValid    (repeatValid),
    .repeatTag      (repeatTag),
    .setPriMa       (setPriMa),
    .setSecMa       (setSecMa),
    .discardPost    (discardPost),
    .cfgDisconnect  (cfgDisconnect),
    .serrN          (serrN),
    .suppressDevsel (suppressDevsel),
    .retireValid    (retireValid),
    .retireTag      (retireTag)
  );

endmodule

// File: tb/abort_handler_tb_top.sv
module abort_handler_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameN = 1'b1, devselN = 1'b1;
  logic [1:0] txnClass = 2'd0, txnTag = 2'd0, repeatTag = 2'd0;
  logic txnOnSec = 1'b0, maMode = 1'b0, serrEn = 1'b0, postedMaDis = 1'b0;
  logic repeatValid = 1'b0;
  logic setPriMa, setSecMa, discardPost, cfgDisconnect, serrN;
  logic suppressDevsel, retireValid;
  logic [1:0] retireTag;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  abort_handler dut_i (
    .clk(clk), .rstN(rstN), .frameN(frameN), .devselN(devselN),
    .txnClass(txnClass), .txnTag(txnTag), .txnOnSec(txnOnSec),
    .maMode(maMode), .serrEn(serrEn), .postedMaDis(postedMaDis),
    .repeatValid(repeatValid), .repeatTag(repeatTag),
    .setPriMa(setPriMa), .setSecMa(setSecMa), .discardPost(discardPost),
    .cfgDisconnect(cfgDisconnect), .serrN(serrN),
    .suppressDevsel(suppressDevsel), .retireValid(retireValid),
    .retireTag(retireTag)
  );

  // cls, tag, onSec, devsel edge (0 = never), maMode, serrEn, dis,
  // expected {pri, sec, discard, serr asserted, cfgDisconnect}
  typedef struct packed {
    logic [1:0] cls;
    logic [1:0] tag;
    logic       sec;
    logic [2:0] devAt;
    logic       mm;
    logic       se;
    logic       dis;
    logic [4:0] exp;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 2'd1, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 5'b10000},
    '{2'd1, 2'd2, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0, 5'b01000},
    '{2'd2, 2'd0, 1'b0, 3'd0, 1'b1, 1'b1, 1'b0, 5'b10110},
    '{2'd2, 2'd0, 1'b1, 3'd0, 1'b1, 1'b1, 1'b1, 5'b01100},
    '{2'd2, 2'd0, 1'b0, 3'd0, 1'b0, 1'b1, 1'b0, 5'b10100},
    '{2'd2, 2'd0, 1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 5'b10100},
    '{2'd3, 2'd0, 1'b1, 3'd0, 1'b1, 1'b1, 1'b0, 5'b00001},
    '{2'd0, 2'd3, 1'b0, 3'd5, 1'b0, 1'b0, 1'b0, 5'b00000},
    '{2'd2, 2'd0, 1'b0, 3'd6, 1'b1, 1'b1, 1'b0, 5'b10110},
    '{2'd0, 2'd0, 1'b1, 3'd2, 1'b0, 1'b0, 1'b0, 5'b00000}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [4:0] outs();
    return {setPriMa, setSecMa, discardPost, !serrN, cfgDisconnect};
  endfunction

  // Drive one target-bus cycle; leaves the caller at the negedge after edge 6.
  task automatic startTxn(input vec_t v);
    @(negedge clk);
    txnClass = v.cls; txnTag = v.tag; txnOnSec = v.sec;
    maMode = v.mm; serrEn = v.se; postedMaDis = v.dis;
    frameN = 1'b0;
    devselN = (v.devAt == 3'd1) ? 1'b0 : 1'b1;
    for (int k = 2; k <= 6; k++) begin
      @(negedge clk);
      devselN = (v.devAt != 3'd0 && k >= int'(v.devAt)) ? 1'b0 : 1'b1;
    end
    @(negedge clk);
  endtask

  task automatic endTxn();
    frameN = 1'b1; devselN = 1'b1;
    @(negedge clk);
    chk("R1", "outputs one cycle after abort", 32'(outs()), 32'd0);
  endtask

  task automatic checkOuts(input logic [4:0] exp);
    chk("R2", "primary status", 32'(setPriMa), 32'(exp[4]));
    chk("R2", "secondary status", 32'(setSecMa), 32'(exp[3]));
    chk("R5", "discard", 32'(discardPost), 32'(exp[2]));
    chk("R6", "serr asserted", 32'(!serrN), 32'(exp[1]));
    chk("R7", "cfg disconnect", 32'(cfgDisconnect), 32'(exp[0]));
    if (exp == 5'd0) chk("R8", "claimed cycle silent", 32'(outs()), 32'd0);
  endtask

  task automatic doRepeat(input logic [1:0] tag, input logic expSup, input string req);
    @(negedge clk);
    repeatValid = 1'b1; repeatTag = tag;
    #1;
    chk(req, "suppressDevsel", 32'(suppressDevsel), 32'(expSup));
    @(negedge clk);
    repeatValid = 1'b0;
    chk("R4", "retireValid", 32'(retireValid), 32'(expSup));
    if (expSup) chk("R4", "retireTag", 32'(retireTag), 32'(tag));
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    vec_t v;
    repeat (3) @(negedge clk);
    chk("R9", "reset outputs", 32'({outs(), suppressDevsel, retireValid}), 32'd0);
    rstN = 1'b1;

    // Table walk: classes, sides, register gating, window edges 5 and 6
    for (int i = 0; i < NV; i++) begin
      startTxn(VECS[i]);
      checkOuts(VECS[i].exp);
      endTxn();
    end

    // Marks now held: tag1 (row 0) and tag2 (row 1)
    doRepeat(2'd3, 1'b0, "R10");   // claimed earlier, not marked
    doRepeat(2'd1, 1'b1, "R3");
    doRepeat(2'd1, 1'b0, "R4");    // mark already removed

    // Same cycle: new delayed abort on tag3 while tag2 is repeated
    v = '{2'd1, 2'd3, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 5'b10000};
    startTxn(v);
    repeatValid = 1'b1; repeatTag = 2'd2;
    #1;
    chk("R3", "old tag suppressed during new abort", 32'(suppressDevsel), 32'd1);
    chk("R2", "status during concurrent repeat", 32'(setPriMa), 32'd1);
    frameN = 1'b1; devselN = 1'b1;
    @(negedge clk);
    repeatValid = 1'b0;
    chk("R4", "concurrent retireValid", 32'(retireValid), 32'd1);
    chk("R4", "concurrent retireTag", 32'(retireTag), 32'd2);
    doRepeat(2'd3, 1'b1, "R3");    // new mark was recorded
    doRepeat(2'd2, 1'b0, "R10");

    // Reset drops a pending mark
    v = '{2'd0, 2'd0, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0, 5'b01000};
    startTxn(v);
    checkOuts(v.exp);
    endTxn();
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    doRepeat(2'd0, 1'b0, "R9");

    // Claim on edge 5 right after reset still inside the window
    v = '{2'd2, 2'd0, 1'b0, 3'd5, 1'b1, 1'b1, 1'b0, 5'b00000};
    startTxn(v);
    checkOuts(v.exp);
    endTxn();

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule